// File: doc/BRIEF.md
# Dual-Product Multiply-Accumulate Slice

This block is one arithmetic slice of a data ALU. It holds two 16x16 signed fractional multipliers and combines their products with a 40-bit accumulator value in one of three ways. Each 32-bit operand carries an upper and a lower 16-bit half. A single-product operation uses only the upper halves. A dot-product operation adds both half-products into the full 40-bit accumulator. A split-lane operation treats the accumulator as two separate 20-bit lanes, and each lane takes one product.

The surrounding datapath presents the two operands, the current accumulator value, a 2-bit operation code and a saturate control, all qualified by a valid strobe. Two cycles later the slice returns the updated accumulator with its own valid strobe. A new operation can be issued on every cycle. Operand fetch, register write-back and instruction decode stay outside the slice.

Top module: `pair_mac_unit`

## Requirements
- R1: Each half-product is the signed 16x16 product of two two's-complement fractions shifted left by one bit, giving a 32-bit result. The case 0x8000 times 0x8000 yields 0x7FFFFFFF.
- R2: Operation code 00 (single) produces the accumulator plus the sign-extended product of the two upper halves. The lower halves have no effect.
- R3: Operation code 01 (dual) produces the accumulator plus the upper-half product plus the lower-half product, evaluated as one 40-bit sum.
- R4: In codes 00 and 01 with the saturate control low, the result wraps modulo 2^40.
- R5: In codes 00 and 01 with the saturate control high, the result clamps to the range 0x80_0000_0000 through 0x7F_FFFF_FFFF.
- R6: Operation code 10 (split-lane) treats accumulator bits 39:20 as the upper lane and bits 19:0 as the lower lane. The upper lane adds bits 31:16 of the upper-half product, sign-extended to 20 bits. The lower lane does the same with the lower-half product.
- R7: In code 10 each lane wraps modulo 2^20 when the saturate control is low, and clamps to -2^19 through 2^19-1 when it is high. No carry or saturation in one lane affects the other lane.
- R8: Operation code 11 returns the accumulator input unchanged, whatever the operands and the saturate control are.
- R9: A result and its valid strobe appear exactly two clock cycles after the operation is presented, and a new operation is accepted on every cycle.
- R10: During and after reset the valid output is low and the accumulator output is zero. The accumulator output holds its last value while no valid result is delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation presented this cycle |
| op | input | 2 | Operation code (00 single, 01 dual, 10 split-lane, 11 pass) |
| sat_en | input | 1 | Saturate instead of wrap |
| opa | input | 32 | First operand, upper and lower 16-bit halves |
| opb | input | 32 | Second operand, upper and lower 16-bit halves |
| acc_in | input | 40 | Accumulator value to update |
| out_valid | output | 1 | Result valid |
| acc_out | output | 40 | Updated accumulator |

## Verification
Several properties are checked on every cycle. The two-cycle valid latency and the pass-through code are checked. The registered half-products never take the wrapped value 0x80000000. The lower halves have no effect in the single operation. A lane whose product is zero comes out of a split-lane operation unchanged, even while the other lane overflows. The exact sums are shown only by the bench's scenarios: the 40-bit wrap and clamp points, clamping of each lane at its own limits, and the -1 times -1 corner inside a real accumulation. The bench's reference model follows every cycle of a mixed directed and pseudo-random stream.

// File: rtl/mac_pkg.sv
package mac_pkg;
  localparam int HALF_W = 16;
  localparam int PROD_W = 2 * HALF_W;
  localparam int ACC_W  = 40;
  localparam int LANE_W = ACC_W / 2;

  typedef enum logic [1:0] {
    OP_SINGLE = 2'b00,
    OP_DUAL   = 2'b01,
    OP_SPLIT  = 2'b10,
    OP_PASS   = 2'b11
  } mac_op_e;

  // Fractional product: doubled, with the one overflowing case pinned to max.
  function automatic logic [PROD_W-1:0] frac_mul(input logic [HALF_W-1:0] a,
                                                 input logic [HALF_W-1:0] b);
    logic signed [PROD_W-1:0] raw;
    logic [HALF_W-1:0] most_neg;
    most_neg = {1'b1, {(HALF_W-1){1'b0}}};
    raw = $signed(a) * $signed(b);
    if (a == most_neg && b == most_neg)
      return {1'b0, {(PROD_W-1){1'b1}}};
    return {raw[PROD_W-2:0], 1'b0};
  endfunction

  // Two guard bits above the accumulator cover a sum of three terms.
  function automatic logic [ACC_W-1:0] fit_acc(input logic signed [ACC_W+1:0] s,
                                               input logic sat);
    logic signed [ACC_W+1:0] hi_lim, lo_lim;
    hi_lim = {3'b000, {(ACC_W-1){1'b1}}};
    lo_lim = {3'b111, {(ACC_W-1){1'b0}}};
    if (sat && s > hi_lim) return hi_lim[ACC_W-1:0];
    if (sat && s < lo_lim) return lo_lim[ACC_W-1:0];
    return s[ACC_W-1:0];
  endfunction

  function automatic logic [LANE_W-1:0] fit_lane(input logic signed [LANE_W:0] s,
                                                 input logic sat);
    logic signed [LANE_W:0] hi_lim, lo_lim;
    hi_lim = {2'b00, {(LANE_W-1){1'b1}}};
    lo_lim = {2'b11, {(LANE_W-1){1'b0}}};
    if (sat && s > hi_lim) return hi_lim[LANE_W-1:0];
    if (sat && s < lo_lim) return lo_lim[LANE_W-1:0];
    return s[LANE_W-1:0];
  endfunction
endpackage

// File: rtl/frac_mul.sv
module frac_mul #(
  parameter int HW = mac_pkg::HALF_W
) (
  input  logic [HW-1:0]   a,
  input  logic [HW-1:0]   b,
  output logic [2*HW-1:0] p
);
  always_comb p = mac_pkg::frac_mul(a, b);
endmodule

// File: rtl/mac_combine.sv
module mac_combine #(
  parameter int PW = mac_pkg::PROD_W,
  parameter int AW = mac_pkg::ACC_W
) (
  input  logic [1:0]    op,
  input  logic          sat,
  input  logic [AW-1:0] acc,
  input  logic [PW-1:0] p_hi,
  input  logic [PW-1:0] p_lo,
  output logic [AW-1:0] result
);
  import mac_pkg::*;
  localparam int LW = AW / 2;
  localparam int HW = PW / 2;

  logic signed [AW+1:0] sum_single, sum_dual;
  logic signed [LW:0]   lane_hi, lane_lo;

  always_comb begin
    sum_single = $signed({{2{acc[AW-1]}}, acc}) +
                 $signed({{(AW+2-PW){p_hi[PW-1]}}, p_hi});
    sum_dual   = sum_single + $signed({{(AW+2-PW){p_lo[PW-1]}}, p_lo});
    lane_hi    = $signed({acc[AW-1], acc[AW-1:LW]}) +
                 $signed({{(LW+1-HW){p_hi[PW-1]}}, p_hi[PW-1:HW]});
    lane_lo    = $signed({acc[LW-1], acc[LW-1:0]}) +
                 $signed({{(LW+1-HW){p_lo[PW-1]}}, p_lo[PW-1:HW]});
    unique case (mac_op_e'(op))
      OP_SINGLE: result = fit_acc(sum_single, sat);
      OP_DUAL:   result = fit_acc(sum_dual, sat);
      OP_SPLIT:  result = {fit_lane(lane_hi, sat), fit_lane(lane_lo, sat)};
      default:   result = acc;
    endcase
  end
endmodule

// File: rtl/pair_mac_unit.sv
module pair_mac_unit #(
  parameter int HALF_W = mac_pkg::HALF_W,
  parameter int ACC_W  = mac_pkg::ACC_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [1:0]          op,
  input  logic                sat_en,
  input  logic [2*HALF_W-1:0] opa,
  input  logic [2*HALF_W-1:0] opb,
  input  logic [ACC_W-1:0]    acc_in,
  output logic                out_valid,
  output logic [ACC_W-1:0]    acc_out
);
  localparam int PROD_W = 2 * HALF_W;
  localparam int NMUL   = 2;

  logic [PROD_W-1:0] prod_comb [NMUL];
  logic [PROD_W-1:0] s1_prod   [NMUL];
  logic              s1_valid;
  logic [1:0]        s1_op;
  logic              s1_sat;
  logic [ACC_W-1:0]  s1_acc;
  logic [ACC_W-1:0]  s2_result;

  // Named taps for the checker.
  logic [PROD_W-1:0] prod_hi_q, prod_lo_q;
  assign prod_hi_q = s1_prod[1];
  assign prod_lo_q = s1_prod[0];

  // Index 1 takes the upper halves, index 0 the lower halves.
  for (genvar g = 0; g < NMUL; g++) begin : g_mul
    frac_mul #(.HW(HALF_W)) u_mul (
      .a(opa[g*HALF_W +: HALF_W]),
      .b(opb[g*HALF_W +: HALF_W]),
      .p(prod_comb[g])
    );
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) s1_prod[g] <= '0;
      else if (in_valid) s1_prod[g] <= prod_comb[g];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_op    <= '0;
      s1_sat   <= 1'b0;
      s1_acc   <= '0;
    end else begin
      s1_valid <= in_valid;
      if (in_valid) begin
        s1_op  <= op;
        s1_sat <= sat_en;
        s1_acc <= acc_in;
      end
    end
  end

  mac_combine #(.PW(PROD_W), .AW(ACC_W)) u_comb (
    .op(s1_op),
    .sat(s1_sat),
    .acc(s1_acc),
    .p_hi(s1_prod[1]),
    .p_lo(s1_prod[0]),
    .result(s2_result)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      acc_out   <= '0;
    end else begin
      out_valid <= s1_valid;
      if (s1_valid) acc_out <= s2_result;
    end
  end
endmodule

// File: rtl/pair_mac_unit_chk.sv
module pair_mac_unit_chk #(
  parameter int HALF_W = 16,
  parameter int ACC_W  = 40
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_valid,
  input logic [1:0]          op,
  input logic [2*HALF_W-1:0] opa,
  input logic [2*HALF_W-1:0] opb,
  input logic [ACC_W-1:0]    acc_in,
  input logic                out_valid,
  input logic [ACC_W-1:0]    acc_out,
  input logic                s1_valid,
  input logic [2*HALF_W-1:0] prod_hi_q,
  input logic [2*HALF_W-1:0] prod_lo_q
);
  localparam int LW = ACC_W / 2;
  localparam logic [2*HALF_W-1:0] WRAPPED = {1'b1, {(2*HALF_W-1){1'b0}}};

  logic [1:0] settle;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) settle <= '0;
    else if (settle != 2'd2) settle <= settle + 2'd1;
  end

  p_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (settle == 2'd2) |-> (out_valid == $past(in_valid, 2)));

  p_reset_clear_r10: assert property (@(posedge clk)
    !rst_n |=> (!out_valid && acc_out == '0));

  p_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (settle == 2'd2 && $past(in_valid, 2) && $past(op, 2) == 2'b11)
      |-> (acc_out == $past(acc_in, 2)));

  p_no_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid |-> (prod_hi_q != WRAPPED && prod_lo_q != WRAPPED));

  p_low_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (settle == 2'd2 && $past(in_valid, 2) && $past(op, 2) == 2'b00 &&
     $past(opa[2*HALF_W-1:HALF_W], 2) == '0)
      |-> (acc_out == $past(acc_in, 2)));

  p_lane_lo_isolated_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (settle == 2'd2 && $past(in_valid, 2) && $past(op, 2) == 2'b10 &&
     $past(opa[HALF_W-1:0], 2) == '0)
      |-> (acc_out[LW-1:0] == $past(acc_in[LW-1:0], 2)));

  p_lane_hi_isolated_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (settle == 2'd2 && $past(in_valid, 2) && $past(op, 2) == 2'b10 &&
     $past(opa[2*HALF_W-1:HALF_W], 2) == '0)
      |-> (acc_out[ACC_W-1:LW] == $past(acc_in[ACC_W-1:LW], 2)));
endmodule

bind pair_mac_unit pair_mac_unit_chk #(.HALF_W(HALF_W), .ACC_W(ACC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .opa(opa), .opb(opb),
  .acc_in(acc_in), .out_valid(out_valid), .acc_out(acc_out),
  .s1_valid(s1_valid), .prod_hi_q(prod_hi_q), .prod_lo_q(prod_lo_q)
);

// File: tb/sim_pair_mac_unit.sv
module sim_pair_mac_unit;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [1:0]  op = '0;
  logic        sat_en = 1'b0;
  logic [31:0] opa = '0, opb = '0;
  logic [39:0] acc_in = '0;
  logic        out_valid;
  logic [39:0] acc_out;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  pair_mac_unit u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .sat_en(sat_en),
    .opa(opa), .opb(opb), .acc_in(acc_in), .out_valid(out_valid), .acc_out(acc_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    bit          v;
    logic [39:0] acc;
    string       tag;
  } exp_t;

  exp_t        exp_q[$];
  logic [39:0] model_acc = '0;

  function automatic longint fprod(int a, int b);
    if (a == -32768 && b == -32768) return 64'sd2147483647;
    return longint'(a) * longint'(b) * 2;
  endfunction

  function automatic logic [39:0] clamp40(longint s, bit sat);
    longint lim;
    logic [63:0] w;
    lim = longint'(1) <<< 39;
    if (sat && s > lim - 1) s = lim - 1;
    if (sat && s < -lim) s = -lim;
    w = s;
    return w[39:0];
  endfunction

  function automatic logic [19:0] clamp20(longint s, bit sat);
    logic [63:0] w;
    if (sat && s > 524287) s = 524287;
    if (sat && s < -524288) s = -524288;
    w = s;
    return w[19:0];
  endfunction

  function automatic longint sx(logic [39:0] v, int w);
    longint r;
    r = 0;
    for (int i = 0; i < 64; i++) r[i] = (i < w) ? v[i] : v[w-1];
    return r;
  endfunction

  function automatic exp_t predict(bit v, logic [1:0] o, bit s,
                                   logic [31:0] a, logic [31:0] b, logic [39:0] acc);
    exp_t e;
    longint ph, pl, sum;
    ph = fprod(int'($signed(a[31:16])), int'($signed(b[31:16])));
    pl = fprod(int'($signed(a[15:0])), int'($signed(b[15:0])));
    e.v = v;
    e.tag = "R10";
    if (!v) begin
      e.acc = model_acc;
      return e;
    end
    case (o)
      2'b00: begin
        sum = sx(acc, 40) + ph;
        e.acc = clamp40(sum, s);
        e.tag = s ? "R2 R5" : "R2 R4";
      end
      2'b01: begin
        sum = sx(acc, 40) + ph + pl;
        e.acc = clamp40(sum, s);
        e.tag = s ? "R3 R5" : "R3 R4";
      end
      2'b10: begin
        e.acc[39:20] = clamp20(sx({20'd0, acc[39:20]}, 20) + (ph >>> 16), s);
        e.acc[19:0]  = clamp20(sx({20'd0, acc[19:0]}, 20) + (pl >>> 16), s);
        e.tag = "R6 R7";
      end
      default: begin
        e.acc = acc;
        e.tag = "R8";
      end
    endcase
    if (a[31:16] == 16'h8000 && b[31:16] == 16'h8000) e.tag = {e.tag, " R1"};
    return e;
  endfunction

  task automatic compare_out();
    exp_t e;
    e = exp_q.pop_front();
    checks++;
    if (out_valid !== e.v || acc_out !== e.acc) begin
      failures++;
      $display("FAIL %s R9: got valid=%0b acc=%h, expected valid=%0b acc=%h",
               e.tag, out_valid, acc_out, e.v, e.acc);
    end
  endtask

  task automatic step(bit v, logic [1:0] o, bit s,
                      logic [31:0] a, logic [31:0] b, logic [39:0] acc);
    exp_t e;
    @(negedge clk);
    compare_out();
    in_valid = v;
    op = o;
    sat_en = s;
    opa = a;
    opb = b;
    acc_in = acc;
    e = predict(v, o, s, a, b, acc);
    model_acc = e.acc;
    exp_q.push_back(e);
  endtask

  initial begin
    exp_t idle;
    repeat (3) @(negedge clk);
    // R10: state held in reset
    checks++;
    if (out_valid !== 1'b0 || acc_out !== 40'd0) begin
      failures++;
      $display("FAIL R10: got valid=%0b acc=%h, expected valid=0 acc=0", out_valid, acc_out);
    end
    rst_n = 1'b1;
    idle.v = 1'b0;
    idle.acc = '0;
    idle.tag = "R10";
    exp_q.push_back(idle);
    exp_q.push_back(idle);

    // R1: -1 x -1 in both halves, dot-product
    step(1, 2'b01, 0, 32'h8000_8000, 32'h8000_8000, 40'd0);
    // R2: lower halves ignored
    step(1, 2'b00, 0, 32'h4000_7FFF, 32'h2000_8000, 40'h00_0000_0100);
    // R4: wrap past the positive 40-bit limit
    step(1, 2'b00, 0, 32'h7FFF_0000, 32'h7FFF_0000, 40'h7F_FFFF_FFF0);
    // R5: clamp at the positive limit
    step(1, 2'b00, 1, 32'h7FFF_0000, 32'h7FFF_0000, 40'h7F_FFFF_FFF0);
    // R5: clamp at the negative limit through the dual sum
    step(1, 2'b01, 1, 32'h8000_8000, 32'h7FFF_7FFF, 40'h80_0000_0010);
    // R4: negative wrap through the dual sum
    step(1, 2'b01, 0, 32'h8000_8000, 32'h7FFF_7FFF, 40'h80_0000_0010);
    // R7: lower lane overflows, upper lane untouched
    step(1, 2'b10, 0, 32'h0000_7FFF, 32'h1234_7FFF, 40'h12345_7FFF0);
    // R7: lower lane saturates, upper lane adds normally
    step(1, 2'b10, 1, 32'h4000_7FFF, 32'h4000_7FFF, 40'h00010_7FFF0);
    // R7: upper lane clamps negative, lower lane -1 x -1
    step(1, 2'b10, 1, 32'h8000_8000, 32'h7FFF_8000, 40'h80005_00000);
    // R8: pass-through with saturate set
    step(1, 2'b11, 1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 40'hA5_5A5A_A5A5);
    // R10: hold through an idle gap
    step(0, 2'b01, 0, 32'h1111_1111, 32'h2222_2222, 40'h0);
    step(0, 2'b00, 1, 32'h3333_3333, 32'h4444_4444, 40'h1);
    // R9: back-to-back mixed stream
    for (int i = 0; i < 400; i++) begin
      logic [31:0] ra, rb;
      logic [39:0] rc;
      ra = $urandom();
      rb = $urandom();
      rc = {$urandom(), $urandom()};
      if (i % 17 == 0) ra[31:16] = 16'h8000;
      if (i % 17 == 0) rb[31:16] = 16'h8000;
      if (i % 5 == 0) rc[39:30] = {10{rc[39]}} ^ 10'h1FF;
      step(($urandom() % 8) != 0, 2'($urandom()), 1'($urandom()), ra, rb, rc);
    end
    step(0, 2'b00, 0, '0, '0, '0);
    step(0, 2'b00, 0, '0, '0, '0);
    step(0, 2'b00, 0, '0, '0, '0);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL R9: watchdog expired, got no end, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule